// File: doc/BRIEF.md
# Multi-Lane TDM Output Serializer

The serializer turns a stream of 64-bit words into time-division-multiplexed audio on a set of serial data lanes (four by default). Each word is cut into 8, 4 or 2 samples according to the configured sample width. Each sample is placed at the top of a slot and shifted out most-significant bit first. The block does not generate clocks. It follows a bit strobe, which marks each bit-clock falling edge, and a frame strobe that marks bit 0 of a frame.

A frame starts at the frame strobe. After a programmable number of leading bits comes a run of back-to-back slots, all of the same width. Per lane and per slot, a slot mask chooses between real data and a constant "masked" word, and a mute map replaces the data with a constant "muted" word. Samples are handed out in slot order and, within a slot, in lane order. A small loader prepares the words for the next slot while the current slot is on the wire. The FIFO is popped only after every sample of the held word has been used. When the FIFO has nothing to give, the lane sends zeros and an underrun pulse is raised.

Top module: `tdm_out_serializer`

## Requirements
- R1: While reset is asserted and right after it is released, every lane output is 0, `fifo_pop` is 0 and `underrun` is 0.
- R2: The slot count, slot width and sample width inputs hold the true value minus one. The frame strobe is bit 0. The first slot begins `cfg_bit_offset` bits later (0 means it begins on bit 0), and the slots follow with no gap. Before the first slot and after the last slot, every lane drives 0.
- R3: The word is split into 8-bit containers when the sample width is at most 8, 16-bit containers when it is at most 16, and 32-bit containers otherwise. Container i occupies word bits [C*i+C-1 : C*i], and container 0 is used first. A new word is popped only after all of the held word's containers have been used, and never while `fifo_empty` is high.
- R4: A sample is the upper (sample width) bits of its container. It is sent MSB first from the first bit of the slot. The remaining bits of the slot are 0. When the slot is shorter than the sample, only the leading slot-width bits are sent.
- R5: Samples go to data slots in slot order. Within one slot they go to lane 0 first, then lane 1, and so on.
- R6: Lane l uses mask bits `cfg_lane_mask[32*l + s]`, where s is the slot number. When the bit is clear, slot s on lane l sends `cfg_mask_value` MSB first (bit 31 first) and does not use a sample.
- R7: Lane l uses mute bits `cfg_lane_mute[32*l + s]`. When the bit is set and the mask bit is set, the slot sends `cfg_mute_value` MSB first and the sample it would have carried is dropped. A clear mask bit takes precedence over mute.
- R8: Lane outputs change only in the clock after a cycle in which `bit_stb` is high. `frame_stb` has an effect only in a cycle where `bit_stb` is also high.
- R9: When a data slot needs a sample and none is held or available, that lane sends 0 for the data part and `underrun` is high for one clock.
- R10: While `enable` is low, no word is popped, all lanes drive 0 from the next clock, and strobes are ignored. Once `enable` returns, output resumes at the next frame strobe and continues from the retained unpacking position.
- R11: Consecutive `bit_stb` pulses must be at least LANES+2 clocks apart, so that all next-slot words are staged before the slot begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low halts FIFO reads and silences lanes |
| bit_stb | input | 1 | One-clock pulse per bit-clock falling edge |
| frame_stb | input | 1 | Frame start, qualified by `bit_stb` |
| cfg_bit_offset | input | 5 | Bit position of the first slot after frame start |
| cfg_slot_count_m1 | input | 5 | Slots per frame minus one |
| cfg_slot_width_m1 | input | 5 | Bits per slot minus one |
| cfg_sample_width_m1 | input | 5 | Bits per sample minus one |
| cfg_lane_mask | input | LANES*32 | Per-lane slot masks, lane l at bits [32*l+31:32*l] |
| cfg_lane_mute | input | LANES*32 | Per-lane mute maps, same layout |
| cfg_mask_value | input | 32 | Word sent in masked slots |
| cfg_mute_value | input | 32 | Word sent in muted slots |
| fifo_data | input | 64 | Head word of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word at this clock edge |
| lane_dout | output | LANES | Serial data, one bit per lane |
| underrun | output | 1 | One-clock pulse per starved sample |

## Verification
The situation that is hardest to create from the ports is a word boundary that falls in the middle of one slot's lane sequence. The loader must then finish the held word for the lower lanes and pop a fresh word for the higher ones, all within the few clocks between two bit strobes. The stimulus forces this by combining 32-bit containers (two samples per word) with four data lanes, and by using masked slots so that the number of samples per slot is odd. A bit-accurate reference model consumes words at slot start and is compared with the lanes on every clock. A starved FIFO and an enable drop in the middle of a run are driven as separate cases.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  localparam int WORD_W  = 64;
  localparam int SLOT_W  = 32;
  localparam int FIELD_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GAP  = 2'd1,
    PH_SLOT = 2'd2,
    PH_TAIL = 2'd3
  } phase_e;

  // Container size code from the sample width: 0 -> 8 bit, 1 -> 16 bit, 2 -> 32 bit
  function automatic logic [1:0] container_sel(input logic [FIELD_W-1:0] sw_m1);
    if (sw_m1 < 5'd8)       return 2'd0;
    else if (sw_m1 < 5'd16) return 2'd1;
    else                    return 2'd2;
  endfunction

  function automatic logic [3:0] per_word(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd8;
      2'd1:    return 4'd4;
      default: return 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_ser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               bit_stb,
  input  logic               frame_stb,
  input  logic [FIELD_W-1:0] cfg_bit_offset,
  input  logic [FIELD_W-1:0] cfg_slot_count_m1,
  input  logic [FIELD_W-1:0] cfg_slot_width_m1,
  output logic               slot_start,
  output logic               in_slot,
  output logic [FIELD_W-1:0] slot_idx
);

  phase_e             phase_q, phase_d;
  logic [FIELD_W-1:0] gap_q, gap_d;
  logic [FIELD_W-1:0] slot_q, slot_d;
  logic [FIELD_W-1:0] bit_q, bit_d;
  logic               step;

  assign step = enable & bit_stb;

  always_comb begin
    phase_d = phase_q;
    gap_d   = gap_q;
    slot_d  = slot_q;
    bit_d   = bit_q;
    if (!enable) begin
      phase_d = PH_IDLE;
    end else if (step) begin
      if (frame_stb) begin
        slot_d = '0;
        bit_d  = '0;
        gap_d  = '0;
        phase_d = (cfg_bit_offset == '0) ? PH_SLOT : PH_GAP;
      end else begin
        case (phase_q)
          PH_GAP: begin
            if (gap_q + 5'd1 == cfg_bit_offset) begin
              phase_d = PH_SLOT;
              slot_d  = '0;
              bit_d   = '0;
            end else begin
              gap_d = gap_q + 5'd1;
            end
          end
          PH_SLOT: begin
            if (bit_q == cfg_slot_width_m1) begin
              bit_d = '0;
              if (slot_q == cfg_slot_count_m1) phase_d = PH_TAIL;
              else                              slot_d  = slot_q + 5'd1;
            end else begin
              bit_d = bit_q + 5'd1;
            end
          end
          default: phase_d = phase_q;
        endcase
      end
    end
  end

  assign in_slot    = step && (phase_d == PH_SLOT);
  assign slot_start = in_slot && (bit_d == '0);
  assign slot_idx   = slot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      gap_q   <= '0;
      slot_q  <= '0;
      bit_q   <= '0;
    end else begin
      phase_q <= phase_d;
      gap_q   <= gap_d;
      slot_q  <= slot_d;
      bit_q   <= bit_d;
    end
  end

  // R2: a slot never runs past the configured slot count
  assert_slot_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot |-> (slot_idx <= cfg_slot_count_m1));

endmodule

// File: rtl/tdm_sample_loader.sv
module tdm_sample_loader
  import tdm_ser_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    slot_start,
  input  logic [FIELD_W-1:0]      slot_idx,
  input  logic [FIELD_W-1:0]      cfg_slot_count_m1,
  input  logic [FIELD_W-1:0]      cfg_sample_width_m1,
  input  logic [LANES*SLOT_W-1:0] cfg_lane_mask,
  input  logic [LANES*SLOT_W-1:0] cfg_lane_mute,
  input  logic [SLOT_W-1:0]       cfg_mask_value,
  input  logic [SLOT_W-1:0]       cfg_mute_value,
  input  logic [WORD_W-1:0]       fifo_data,
  input  logic                    fifo_empty,
  output logic                    fifo_pop,
  output logic [LANES*SLOT_W-1:0] staged,
  output logic                    fill_done,
  output logic                    underrun
);

  localparam int LN_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LN_W-1:0] LAST_LN = LN_W'(LANES - 1);

  logic [WORD_W-1:0]       word_q, word_d;
  logic [3:0]              rem_q, rem_d;
  logic [2:0]              idx_q, idx_d;
  logic                    fill_q, fill_d;
  logic [FIELD_W-1:0]      tgt_q, tgt_d;
  logic [LN_W-1:0]         ln_q, ln_d;
  logic [LANES*SLOT_W-1:0] staged_q, staged_d;
  logic                    und_q, und_d;

  logic              work, mask_bit, mute_bit, take, have_word, pop, starve;
  logic [1:0]        sel;
  logic [3:0]        npw;
  logic [WORD_W-1:0] src_word;
  logic [2:0]        src_idx;
  logic [SLOT_W-1:0] cont, keep, data_word, lane_val;
  logic [5:0]        sw_len;

  assign sel       = container_sel(cfg_sample_width_m1);
  assign npw       = per_word(sel);
  assign work      = enable & fill_q;
  assign mask_bit  = cfg_lane_mask[{ln_q, tgt_q}];
  assign mute_bit  = cfg_lane_mute[{ln_q, tgt_q}];
  assign take      = work & mask_bit;
  assign have_word = (rem_q != 4'd0);
  assign pop       = take & ~have_word & ~fifo_empty;
  assign starve    = take & ~have_word & fifo_empty;
  assign src_word  = have_word ? word_q : fifo_data;
  assign src_idx   = have_word ? idx_q : 3'd0;
  assign sw_len    = {1'b0, cfg_sample_width_m1} + 6'd1;
  assign keep      = ~(32'hFFFF_FFFF >> sw_len);

  always_comb begin
    case (sel)
      2'd0:    cont = {src_word[{src_idx, 3'b000} +: 8], 24'h0};
      2'd1:    cont = {src_word[{src_idx[1:0], 4'b0000} +: 16], 16'h0};
      default: cont = src_word[{src_idx[0], 5'b00000} +: 32];
    endcase
  end

  assign data_word = starve ? '0 : (cont & keep);
  assign lane_val  = !mask_bit ? cfg_mask_value :
                     (mute_bit ? cfg_mute_value : data_word);

  always_comb begin
    word_d   = word_q;
    rem_d    = rem_q;
    idx_d    = idx_q;
    fill_d   = fill_q;
    tgt_d    = tgt_q;
    ln_d     = ln_q;
    staged_d = staged_q;
    und_d    = starve;
    if (take && have_word) begin
      idx_d = idx_q + 3'd1;
      rem_d = rem_q - 4'd1;
    end else if (pop) begin
      word_d = fifo_data;
      idx_d  = 3'd1;
      rem_d  = npw - 4'd1;
    end
    if (work) begin
      staged_d[{ln_q, 5'b00000} +: SLOT_W] = lane_val;
      if (ln_q == LAST_LN) begin
        fill_d = 1'b0;
        ln_d   = '0;
      end else begin
        ln_d = ln_q + 1'b1;
      end
    end
    if (slot_start) begin
      fill_d = 1'b1;
      ln_d   = '0;
      tgt_d  = (slot_idx == cfg_slot_count_m1) ? '0 : slot_idx + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      rem_q    <= '0;
      idx_q    <= '0;
      fill_q   <= 1'b1;
      tgt_q    <= '0;
      ln_q     <= '0;
      staged_q <= '0;
      und_q    <= 1'b0;
    end else begin
      word_q   <= word_d;
      rem_q    <= rem_d;
      idx_q    <= idx_d;
      fill_q   <= fill_d;
      tgt_q    <= tgt_d;
      ln_q     <= ln_d;
      staged_q <= staged_d;
      und_q    <= und_d;
    end
  end

  assign fifo_pop  = pop;
  assign staged    = staged_q;
  assign fill_done = ~fill_q;
  assign underrun  = und_q;

  // R3: never pop an empty FIFO
  assert_pop_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R10: no pop while disabled
  assert_no_pop_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !fifo_pop);

  // R9: an underrun pulse only follows a cycle with an empty FIFO
  assert_underrun_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(fifo_empty));

endmodule

// File: rtl/tdm_lane_shift.sv
module tdm_lane_shift
  import tdm_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic              shift,
  input  logic              clear,
  input  logic [SLOT_W-1:0] slot_word,
  output logic              dout
);

  logic [SLOT_W-1:0] sh_q, sh_d;
  logic              dout_q, dout_d;

  always_comb begin
    sh_d   = sh_q;
    dout_d = dout_q;
    if (!enable) begin
      dout_d = 1'b0;
    end else if (load) begin
      dout_d = slot_word[SLOT_W-1];
      sh_d   = {slot_word[SLOT_W-2:0], 1'b0};
    end else if (shift) begin
      dout_d = sh_q[SLOT_W-1];
      sh_d   = {sh_q[SLOT_W-2:0], 1'b0};
    end else if (clear) begin
      dout_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/tdm_out_serializer.sv
module tdm_out_serializer
  import tdm_ser_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    bit_stb,
  input  logic                    frame_stb,
  input  logic [4:0]              cfg_bit_offset,
  input  logic [4:0]              cfg_slot_count_m1,
  input  logic [4:0]              cfg_slot_width_m1,
  input  logic [4:0]              cfg_sample_width_m1,
  input  logic [LANES*32-1:0]     cfg_lane_mask,
  input  logic [LANES*32-1:0]     cfg_lane_mute,
  input  logic [31:0]             cfg_mask_value,
  input  logic [31:0]             cfg_mute_value,
  input  logic [63:0]             fifo_data,
  input  logic                    fifo_empty,
  output logic                    fifo_pop,
  output logic [LANES-1:0]        lane_dout,
  output logic                    underrun
);

  logic                    slot_start, in_slot, fill_done;
  logic [FIELD_W-1:0]      slot_idx;
  logic [LANES*SLOT_W-1:0] staged;
  logic                    shift_en, clear_en;

  tdm_slot_timer u_timer (
    .clk               (clk),
    .rst_n             (rst_n),
    .enable            (enable),
    .bit_stb           (bit_stb),
    .frame_stb         (frame_stb),
    .cfg_bit_offset    (cfg_bit_offset),
    .cfg_slot_count_m1 (cfg_slot_count_m1),
    .cfg_slot_width_m1 (cfg_slot_width_m1),
    .slot_start        (slot_start),
    .in_slot           (in_slot),
    .slot_idx          (slot_idx)
  );

  tdm_sample_loader #(.LANES(LANES)) u_loader (
    .clk                 (clk),
    .rst_n               (rst_n),
    .enable              (enable),
    .slot_start          (slot_start),
    .slot_idx            (slot_idx),
    .cfg_slot_count_m1   (cfg_slot_count_m1),
    .cfg_sample_width_m1 (cfg_sample_width_m1),
    .cfg_lane_mask       (cfg_lane_mask),
    .cfg_lane_mute       (cfg_lane_mute),
    .cfg_mask_value      (cfg_mask_value),
    .cfg_mute_value      (cfg_mute_value),
    .fifo_data           (fifo_data),
    .fifo_empty          (fifo_empty),
    .fifo_pop            (fifo_pop),
    .staged              (staged),
    .fill_done           (fill_done),
    .underrun            (underrun)
  );

  assign shift_en = in_slot & ~slot_start;
  assign clear_en = enable & bit_stb & ~in_slot;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tdm_lane_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .load      (slot_start),
      .shift     (shift_en),
      .clear     (clear_en),
      .slot_word (staged[l*SLOT_W +: SLOT_W]),
      .dout      (lane_dout[l])
    );
  end

  // R11: next-slot words are staged before the slot begins
  assert_staged_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> fill_done);

  // R10: lanes are silent the clock after enable is low
  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (lane_dout == '0));

  // R2: bits outside the slot region are zero
  assert_outside_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bit_stb && !in_slot) |=> (lane_dout == '0));

  // R8: without a bit strobe, lanes hold their value
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !bit_stb) |=> $stable(lane_dout));

endmodule

// File: tb/tdm_out_serializer_bench.sv
module tdm_out_serializer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int STB_GAP    = 8;
  localparam int LANES      = 4;

  logic              clk;
  logic              rst_n;
  logic              enable;
  logic              bit_stb;
  logic              frame_stb;
  logic [4:0]        cfg_bit_offset;
  logic [4:0]        cfg_slot_count_m1;
  logic [4:0]        cfg_slot_width_m1;
  logic [4:0]        cfg_sample_width_m1;
  logic [LANES*32-1:0] cfg_lane_mask;
  logic [LANES*32-1:0] cfg_lane_mute;
  logic [31:0]       cfg_mask_value;
  logic [31:0]       cfg_mute_value;
  logic [63:0]       fifo_data;
  logic              fifo_empty;
  logic              fifo_pop;
  logic [LANES-1:0]  lane_dout;
  logic              underrun;

  tdm_out_serializer #(.LANES(LANES)) u_tdm_out_serializer (
    .clk                 (clk),
    .rst_n               (rst_n),
    .enable              (enable),
    .bit_stb             (bit_stb),
    .frame_stb           (frame_stb),
    .cfg_bit_offset      (cfg_bit_offset),
    .cfg_slot_count_m1   (cfg_slot_count_m1),
    .cfg_slot_width_m1   (cfg_slot_width_m1),
    .cfg_sample_width_m1 (cfg_sample_width_m1),
    .cfg_lane_mask       (cfg_lane_mask),
    .cfg_lane_mute       (cfg_lane_mute),
    .cfg_mask_value      (cfg_mask_value),
    .cfg_mute_value      (cfg_mute_value),
    .fifo_data           (fifo_data),
    .fifo_empty          (fifo_empty),
    .fifo_pop            (fifo_pop),
    .lane_dout           (lane_dout),
    .underrun            (underrun)
  );

  int tests_run = 0;
  int tests_failed = 0;
  string cur_req = "R1";

  // bench FIFO and reference-model state
  logic [63:0] fq[$];
  logic [63:0] wq[$];
  logic [31:0] sq[$];
  logic        pop_req = 1'b0;
  int          pop_cnt = 0;
  int          und_cnt = 0;
  int          starved = 0;
  int          pos = 0;
  bit          pos_valid = 0;
  logic [LANES-1:0] exp_dout = '0;
  logic [31:0] slot_words [LANES];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    tests_failed++;
    $display("FAIL watchdog expired (req %s) actual=hung expected=done", cur_req);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  // sample design pop / underrun away from the edges
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    pop_req = fifo_pop;
    if (fifo_pop) pop_cnt++;
    if (underrun) und_cnt++;
  end

  always @(posedge clk) begin
    if (pop_req && fq.size() > 0) begin
      void'(fq.pop_front());
      fifo_data  <= (fq.size() > 0) ? fq[0] : 64'h0;
      fifo_empty <= (fq.size() == 0);
    end
  end

  function automatic logic [63:0] mix(input int i);
    logic [63:0] v;
    v = 64'(i + 1) * 64'h9E37_79B9_7F4A_7C15;
    return v ^ (v >> 29) ^ 64'h5A5A_0F0F_3C3C_A5A5;
  endfunction

  function automatic logic [31:0] next_sample();
    int c, n;
    logic [63:0] w, cont;
    logic [31:0] v, keep;
    int swl;
    if (sq.size() == 0) begin
      if (wq.size() == 0) begin
        starved++;
        return 32'h0;
      end
      w = wq.pop_front();
      swl = int'(cfg_sample_width_m1) + 1;
      c = (swl <= 8) ? 8 : ((swl <= 16) ? 16 : 32);
      n = 64 / c;
      keep = (swl >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> swl);
      for (int i = 0; i < n; i++) begin
        cont = (w >> (i * c)) & ((64'h1 << c) - 64'h1);
        v = 32'(cont << (32 - c));
        sq.push_back(v & keep);
      end
    end
    return sq.pop_front();
  endfunction

  task automatic model_step();
    int wdt, p, total, k, j;
    if (!rst_n || !enable) begin
      exp_dout = '0;
      pos_valid = 0;
      return;
    end
    if (!bit_stb) return;
    if (frame_stb) begin
      pos = 0;
      pos_valid = 1;
    end else if (pos_valid) begin
      pos++;
    end
    if (!pos_valid) begin
      exp_dout = '0;
      return;
    end
    wdt = int'(cfg_slot_width_m1) + 1;
    p = pos - int'(cfg_bit_offset);
    total = (int'(cfg_slot_count_m1) + 1) * wdt;
    if (p < 0 || p >= total) begin
      exp_dout = '0;
      return;
    end
    k = p / wdt;
    j = p % wdt;
    if (j == 0) begin
      for (int l = 0; l < LANES; l++) begin
        if (!cfg_lane_mask[32*l + k]) begin
          slot_words[l] = cfg_mask_value;
        end else begin
          slot_words[l] = next_sample();
          if (cfg_lane_mute[32*l + k]) slot_words[l] = cfg_mute_value;
        end
      end
    end
    for (int l = 0; l < LANES; l++) exp_dout[l] = slot_words[l][31-j];
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, expv, $time);
    end
  endtask

  // one clock: compare the outputs of the last edge, then drive the next one
  task automatic tick(input logic en, input logic bs, input logic fs);
    @(negedge clk);
    check(lane_dout == exp_dout, {cur_req, " R8"}, "lane_dout", 64'(lane_dout), 64'(exp_dout));
    enable = en;
    bit_stb = bs;
    frame_stb = fs;
    model_step();
  endtask

  task automatic strobe(input logic en, input logic fs);
    tick(en, 1'b1, fs);
    for (int g = 1; g < STB_GAP; g++) tick(en, 1'b0, 1'b0);
  endtask

  task automatic run_frame();
    int nb;
    nb = int'(cfg_bit_offset) + (int'(cfg_slot_count_m1) + 1) * (int'(cfg_slot_width_m1) + 1) + 3;
    strobe(1'b1, 1'b1);
    for (int b = 1; b < nb; b++) strobe(1'b1, 1'b0);
  endtask

  task automatic start_case(input string req, input int off, input int cnt, input int sw_slot,
                            input int sw_samp, input logic [127:0] msk, input logic [127:0] mut,
                            input int nwords);
    @(negedge clk);
    rst_n = 1'b0;
    enable = 1'b0;
    bit_stb = 1'b0;
    frame_stb = 1'b0;
    cur_req = req;
    cfg_bit_offset = 5'(off);
    cfg_slot_count_m1 = 5'(cnt);
    cfg_slot_width_m1 = 5'(sw_slot);
    cfg_sample_width_m1 = 5'(sw_samp);
    cfg_lane_mask = msk;
    cfg_lane_mute = mut;
    fq.delete();
    wq.delete();
    sq.delete();
    starved = 0;
    pos_valid = 0;
    exp_dout = '0;
    for (int i = 0; i < nwords; i++) begin
      fq.push_back(mix(i + nwords * 7));
      wq.push_back(mix(i + nwords * 7));
    end
    fifo_data  = (fq.size() > 0) ? fq[0] : 64'h0;
    fifo_empty = (fq.size() == 0);
    @(negedge clk);
    check(lane_dout == '0 && !fifo_pop && !underrun, "R1", "reset outputs",
          {61'h0, fifo_pop, underrun, |lane_dout}, 64'h0);
    rst_n = 1'b1;
    tick(1'b0, 1'b0, 1'b0);
    check(lane_dout == '0 && !fifo_pop && !underrun, "R1", "after release",
          {61'h0, fifo_pop, underrun, |lane_dout}, 64'h0);
    for (int i = 0; i < STB_GAP; i++) tick(1'b1, 1'b0, 1'b0);
  endtask

  logic [127:0] m;
  logic [127:0] u;
  int pc0;
  int uc0;

  initial begin
    rst_n = 1'b0;
    enable = 1'b0;
    bit_stb = 1'b0;
    frame_stb = 1'b0;
    cfg_bit_offset = '0;
    cfg_slot_count_m1 = '0;
    cfg_slot_width_m1 = '0;
    cfg_sample_width_m1 = '0;
    cfg_lane_mask = '0;
    cfg_lane_mute = '0;
    cfg_mask_value = 32'hA5C3_0F81;
    cfg_mute_value = 32'h3C00_FF17;
    fifo_data = '0;
    fifo_empty = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R5 R11: 8-bit samples in 8-bit slots, four slots, all data, offset 0
    start_case("R3 R5 R11", 0, 3, 7, 7, {128{1'b1}}, '0, 16);
    run_frame();
    run_frame();

    // R4: 12-bit samples (16-bit containers) in 14-bit slots, offset 3
    start_case("R4", 3, 4, 13, 11, {128{1'b1}}, '0, 16);
    run_frame();
    run_frame();

    // R6: masked slots, 16-bit samples in 32-bit slots, offset 1
    m = {128{1'b1}};
    m[32*1 + 1] = 1'b0;
    m[32*1 + 2] = 1'b0;
    m[32*3 + 0] = 1'b0;
    start_case("R6", 1, 2, 31, 15, m, '0, 16);
    run_frame();
    run_frame();

    // R7: mute map, 24-bit samples in 32-bit slots; a masked+muted slot shows mask value
    m = {128{1'b1}};
    m[32*3 + 2] = 1'b0;
    u = '0;
    u[32*0 + 1] = 1'b1;
    u[32*2 + 0] = 1'b1;
    u[32*3 + 2] = 1'b1;
    start_case("R7", 0, 2, 31, 23, m, u, 16);
    run_frame();
    run_frame();

    // R2: offset 5, 1-bit slots, 8 slots (sample truncated to its first bit)
    start_case("R2", 5, 7, 0, 7, {128{1'b1}}, '0, 16);
    run_frame();
    run_frame();

    // R9: starved FIFO, one word for sixteen samples
    start_case("R9", 2, 3, 15, 15, {128{1'b1}}, '0, 1);
    uc0 = und_cnt;
    run_frame();
    check(und_cnt > uc0, "R9", "underrun pulses seen", 64'(und_cnt - uc0), 64'h1);
    check(starved > 0, "R9", "model starved samples", 64'(starved), 64'h1);

    // R10: enable drop after a frame, strobes ignored, no pops, resume at next frame
    start_case("R10", 1, 3, 15, 15, {128{1'b1}}, '0, 16);
    run_frame();
    pc0 = pop_cnt;
    for (int i = 0; i < 6; i++) strobe(1'b0, (i == 0) ? 1'b1 : 1'b0);
    check(pop_cnt == pc0, "R10", "pops while disabled", 64'(pop_cnt - pc0), 64'h0);
    check(lane_dout == '0, "R10", "lanes while disabled", 64'(lane_dout), 64'h0);
    for (int i = 0; i < STB_GAP; i++) tick(1'b1, 1'b0, 1'b0);
    run_frame();

    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule